// File: doc/BRIEF.md
# Interpolating Sigmoid/Tanh Activation Unit

This block evaluates either the logistic sigmoid or the hyperbolic tangent of a signed 16-bit fixed-point operand with 8 fractional bits. Each function has its own table of 2048 precomputed samples. The tables are filled at elaboration time from the real-valued math functions. For each operand the block finds the two neighbouring samples and blends them linearly according to the operand's position between them. The result is a signed fraction with 15 fractional bits.

Operands enter through a valid/ready handshake together with a one-bit function select. Results leave through a second valid/ready handshake in the order the operands were accepted. The three-stage pipeline accepts one operand per clock whenever the consumer is ready. When the consumer stalls, the whole pipeline freezes and input acceptance stops.

Top module: `act_interp_lut`

## Requirements
- R1: With `in_func`=0 (sigmoid), samples sit at x = -64 + k/16 for k = 0..2047. `out_y` lies within 2 LSB of the real linear blend of the ideal sigmoid values at the two neighbouring samples, scaled by 2^15 and clamped to [-32768, 32767]. It is never negative.
- R2: With `in_func`=1 (tanh), samples sit at x = -128 + k/8 for k = 0..2047. `out_y` lies within 2 LSB of the real linear blend of the ideal tanh values at the two neighbouring samples, scaled and clamped as in R1.
- R3: For sigmoid, any operand at or below -64.0 gives 0. Any operand at or above the last sample, 63.9375 (raw 16368), gives 32767.
- R4: For tanh, the operand -128.0 (raw 0x8000) gives -32768. Any operand at or above the last sample, 127.875 (raw 32736), gives 32767.
- R5: An operand accepted in cycle c produces `out_valid` in cycle c+3 when `out_ready` is high in cycles c+1 and c+2.
- R6: `in_ready` is high in every cycle in which `out_ready` is high, so one operand per cycle is accepted.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid` and `out_y` keep their values into the next cycle.
- R8: Each accepted operand yields exactly one result. Results appear in acceptance order.
- R9: While `rst_n` is low, and in the cycle after, `out_valid` is low.
- R10: The function select is captured together with its operand. Operands for the two functions may alternate from one cycle to the next without affecting each other's results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Operand accepted at this edge when high with `in_valid` |
| in_func | input | 1 | Function select: 0 sigmoid, 1 tanh |
| in_x | input | 16 | Signed operand, 8 fractional bits |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result at this edge |
| out_y | output | 16 | Signed result, 15 fractional bits |

## Verification
While the consumer stays ready, each result is due exactly three cycles after its operand is accepted. The bench stamps every accepted operand with the cycle number and checks that the matching result appears in that cycle. During random consumer stalls, the latency check is switched off. In that phase the bench instead checks, cycle by cycle, that a held result and the blocked input stay put until the consumer takes the result. Values are compared against a real-valued model of the sampled-and-blended function, and the saturation corners are compared exactly.

// File: rtl/act_interp_lut.sv
module act_interp_lut #(
  parameter int XW      = 16,
  parameter int XF      = 8,
  parameter int YW      = 16,
  parameter int N_PTS   = 2048,
  parameter int SIG_SH  = 4,
  parameter int TANH_SH = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_func,
  input  logic [XW-1:0] in_x,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [YW-1:0] out_y
);
  localparam int AW = $clog2(N_PTS);
  localparam int FW = (SIG_SH > TANH_SH) ? SIG_SH : TANH_SH;
  localparam int UW = XW + 2;
  localparam int PW = YW + FW + 2;
  localparam logic signed [UW-1:0] SIG_OFF  = UW'((N_PTS << SIG_SH) / 2);
  localparam logic signed [UW-1:0] TANH_OFF = UW'((N_PTS << TANH_SH) / 2);
  localparam logic signed [UW-1:0] SIG_TOP  = UW'((N_PTS - 1) << SIG_SH);
  localparam logic signed [UW-1:0] TANH_TOP = UW'((N_PTS - 1) << TANH_SH);
  localparam logic [AW-1:0] LAST = AW'(N_PTS - 1);

  logic signed [YW-1:0] rom_sig  [N_PTS];
  logic signed [YW-1:0] rom_tanh [N_PTS];

  function automatic logic signed [YW-1:0] to_fix(input real v);
    real s;
    s = $floor(v * real'(64'd1 << (YW - 1)) + 0.5);
    if (s > real'((64'd1 << (YW - 1)) - 1)) s = real'((64'd1 << (YW - 1)) - 1);
    if (s < -real'(64'd1 << (YW - 1))) s = -real'(64'd1 << (YW - 1));
    return YW'($rtoi(s));
  endfunction

  initial begin
    for (int k = 0; k < N_PTS; k++) begin
      real xs, xt;
      xs = real'(k - N_PTS / 2) * real'(1 << SIG_SH) / real'(1 << XF);
      xt = real'(k - N_PTS / 2) * real'(1 << TANH_SH) / real'(1 << XF);
      rom_sig[k]  = to_fix(1.0 / (1.0 + $exp(-xs)));
      rom_tanh[k] = to_fix($tanh(xt));
    end
  end

  logic en;
  logic v1, v2, v3;
  logic f1, f2, f3;
  logic [AW-1:0] i1;
  logic [FW-1:0] w1, w2;
  logic signed [YW-1:0] a2, b2, y3;

  assign en        = out_ready | ~v3;
  assign in_ready  = en;
  assign out_valid = v3;
  assign out_y     = y3;

  // stage 1: position in the sampled span, clamped at both ends
  logic signed [UW-1:0] u, top;
  logic [AW-1:0] idx;
  logic [FW-1:0] wgt;
  assign u   = $signed({{2{in_x[XW-1]}}, in_x}) + (in_func ? TANH_OFF : SIG_OFF);
  assign top = in_func ? TANH_TOP : SIG_TOP;

  always_comb begin
    if (u[UW-1]) begin
      idx = '0;
      wgt = '0;
    end else if (u >= top) begin
      idx = LAST;
      wgt = '0;
    end else if (in_func) begin
      idx = u[TANH_SH +: AW];
      wgt = FW'(u[TANH_SH-1:0]);
    end else begin
      idx = u[SIG_SH +: AW];
      wgt = FW'(u[SIG_SH-1:0]);
    end
  end

  // stage 2 read address of the upper neighbour
  logic [AW-1:0] i1n;
  assign i1n = (i1 == LAST) ? i1 : i1 + 1'b1;

  // stage 3: a + round((b - a) * w / step)
  logic signed [YW:0]   diff;
  logic signed [PW-1:0] prod, q;
  assign diff = {b2[YW-1], b2} - {a2[YW-1], a2};
  assign prod = PW'(diff) * PW'($signed({1'b0, w2}));
  assign q    = f2 ? ((prod + PW'(1 << (TANH_SH - 1))) >>> TANH_SH)
                   : ((prod + PW'(1 << (SIG_SH - 1))) >>> SIG_SH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else if (en) begin
      v1 <= in_valid;
      v2 <= v1;
      v3 <= v2;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      f1 <= in_func;
      i1 <= idx;
      w1 <= wgt;
      f2 <= f1;
      w2 <= w1;
      a2 <= f1 ? rom_tanh[i1]  : rom_sig[i1];
      b2 <= f1 ? rom_tanh[i1n] : rom_sig[i1n];
      f3 <= f2;
      y3 <= YW'(PW'(a2) + q);
    end
  end
endmodule

module act_interp_lut_chk #(
  parameter int YW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [YW-1:0] out_y,
  input logic          fn_q
);
  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 out_ready ##1 out_ready |=> out_valid);

  assert_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_y)));

  assert_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_reset_R9: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  assert_sig_nonneg_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !fn_q) |-> !out_y[YW-1]);
endmodule

bind act_interp_lut act_interp_lut_chk #(.YW(YW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_y(out_y), .fn_q(f3)
);

// File: tb/act_interp_lut_tb_top.sv
module act_interp_lut_tb_top;
  logic clk = 1'b0;
  logic rst_n, in_valid, in_ready, in_func, out_valid, out_ready;
  logic [15:0] in_x, out_y;

  always #2ns clk = ~clk;

  act_interp_lut dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_func(in_func), .in_x(in_x), .out_valid(out_valid),
    .out_ready(out_ready), .out_y(out_y)
  );

  typedef struct {
    int    cyc;
    bit    fn;
    int    raw;
    real   exp;
    real   tol;
    bit    lat;
    string tag;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0, sent = 0, got = 0, cyc = 0;
  bit bp = 0, lat_on = 1, done = 0;
  bit stall_prev = 0;
  logic [15:0] held;

  always @(posedge clk) cyc++;

  function automatic real fval(bit fn, real x);
    return fn ? $tanh(x) : 1.0 / (1.0 + $exp(-x));
  endfunction

  function automatic real ref_val(bit fn, int raw);
    real x, st, lo, pos, t, y;
    int k;
    x  = real'(raw) / 256.0;
    st = fn ? 0.125 : 0.0625;
    lo = fn ? -128.0 : -64.0;
    pos = (x - lo) / st;
    if (pos <= 0.0) y = fval(fn, lo);
    else begin
      k = $rtoi($floor(pos));
      if (k >= 2047) y = fval(fn, lo + 2047.0 * st);
      else begin
        t = pos - real'(k);
        y = fval(fn, lo + k * st) + (fval(fn, lo + (k + 1) * st) - fval(fn, lo + k * st)) * t;
      end
    end
    y = y * 32768.0;
    if (y > 32767.0) y = 32767.0;
    if (y < -32768.0) y = -32768.0;
    return y;
  endfunction

  task automatic send(bit fn, int raw, real tol, string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1;
    in_func  = fn;
    in_x     = 16'(raw);
    if (bp) out_ready = ($urandom_range(2) != 0);
    #1;
    if (!bp) begin
      checks++;
      if (!in_ready) begin
        errors++;
        $display("FAIL R6: in_ready=%0d expected 1 with out_ready high", in_ready);
      end
    end
    while (!in_ready) begin
      @(negedge clk);
      if (bp) out_ready = ($urandom_range(2) != 0);
      #1;
    end
    it.cyc = cyc; it.fn = fn; it.raw = raw;
    it.exp = ref_val(fn, raw); it.tol = tol; it.lat = lat_on; it.tag = tag;
    q.push_back(it);
    sent++;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (stall_prev) begin
        checks++;
        if (!(out_valid && out_y == held)) begin
          errors++;
          $display("FAIL R7: held result changed, got valid=%0d y=%0d expected valid=1 y=%0d",
                   out_valid, $signed(out_y), $signed(held));
        end
      end
      if (out_valid && !out_ready) begin
        checks++;
        if (in_ready) begin
          errors++;
          $display("FAIL R7: in_ready=%0d expected 0 during stall", in_ready);
        end
      end
      stall_prev = out_valid && !out_ready;
      held = out_y;
      if (out_valid && out_ready) begin
        got++;
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R8: result %0d with no pending operand, expected none", $signed(out_y));
        end else begin
          item_t it;
          real d;
          it = q.pop_front();
          d = real'($signed(out_y)) - it.exp;
          if (d < 0.0) d = -d;
          if (d > it.tol) begin
            errors++;
            $display("FAIL %s: fn=%0d x=%0d got %0d expected %f (tol %f)",
                     it.tag, it.fn, it.raw, $signed(out_y), it.exp, it.tol);
          end
          if (it.lat) begin
            checks++;
            if (cyc != it.cyc + 3) begin
              errors++;
              $display("FAIL R5: result in cycle %0d expected cycle %0d", cyc, it.cyc + 3);
            end
          end
        end
      end
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_func = 1'b0; in_x = '0; out_ready = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    checks++;
    if (out_valid) begin
      errors++;
      $display("FAIL R9: out_valid=%0d expected 0 in reset", out_valid);
    end
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if (out_valid) begin
      errors++;
      $display("FAIL R9: out_valid=%0d expected 0 after reset", out_valid);
    end

    // saturation corners and anchors (R3, R4)
    send(0, -32768, 0.5, "R3");
    send(0, -16384, 0.5, "R3");
    send(0, -16385, 0.5, "R3");
    send(0, 16368, 0.5, "R3");
    send(0, 16384, 0.5, "R3");
    send(0, 32767, 0.5, "R3");
    send(1, -32768, 0.5, "R4");
    send(1, 32736, 0.5, "R4");
    send(1, 32767, 0.5, "R4");
    send(0, 0, 0.5, "R1");
    send(1, 0, 0.5, "R2");
    send(1, 256, 2.0, "R2");
    idle();
    repeat (6) @(negedge clk);

    // full-range sweeps, back to back
    for (int r = -32768; r < 32768; r += 5) send(0, r, 2.0, "R1");
    for (int r = -32768; r < 32768; r += 5) send(1, r, 2.0, "R2");
    // alternating select every cycle
    for (int r = -32768; r < 32768; r += 97) send(r[0], r, 2.0, "R10");
    idle();
    repeat (6) @(negedge clk);

    // consumer stalls and input gaps
    bp = 1; lat_on = 0;
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(3) == 0) idle();
      send(n[0], int'($urandom_range(65535)) - 32768, 2.0, n[0] ? "R2" : "R1");
    end
    idle();
    bp = 0;
    @(negedge clk);
    out_ready = 1'b1;
    while (q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);

    checks++;
    if (got != sent) begin
      errors++;
      $display("FAIL R8: results %0d expected %0d", got, sent);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL R8: watchdog expired with %0d results pending, expected 0", q.size());
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule